// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block watches a two-wire serial bus (I2C or SMBus) without ever driving it. Both bus lines pass through a two-flop synchroniser and a per-line deglitch filter, then are registered together as one snapshot. Every decision the block makes is taken from that snapshot, never from the live pins. From reset, and after any protocol error, the monitor holds itself unsynced. It regains sync only once both lines have been high and steady for a programmable number of clock cycles.

Once synced, the monitor detects start, repeated start and stop conditions. It shifts in each nine-bit frame, made of eight data bits sent most significant first and then the acknowledge bit. For every completed byte and for every stop it emits one 16-bit tagged capture word with a one-cycle valid strobe, and it keeps a running count of the words emitted. A clock line that stays high or low too long, or a data line that moves while the clock is high inside a frame, sends it back to the unsynced state. A downstream recorder can store the words. The timeouts are cycle counts supplied as parameters.

Top module: `i2c_observer`

## Requirements
- R1: While reset is held, `synced` is 0, `capValid` is 0 and `wordCount` is 0.
- R2: `synced` rises only after the filtered SCL and SDA have both been high and unchanged for IDLE_CYC cycles. A shorter idle stretch leaves it at 0. The same rule applies when regaining sync after an error.
- R3: A pulse on either line that lasts fewer than FILT_LEN filter sample ticks is ignored and does not alter the captured data.
- R4: A completed byte produces one capture word. Bit 11 is the start flag, bits 10..3 hold the data byte (the first bit received lands in bit 10), bit 2 holds the acknowledge level sampled on the ninth rising clock edge, and bits 15..12 and 1..0 are 0. A byte that directly follows a start has bit 11 set.
- R5: If no stop or restart follows the acknowledge bit, the next nine bits form a continuation byte whose word has bit 11 cleared.
- R6: SDA falling while SCL is high after an acknowledge bit is a repeated start. It emits no word of its own, and the following byte's word has bit 11 set.
- R7: SDA rising while SCL is high after an acknowledge bit is a stop. It emits a capture word equal to 16'h0001.
- R8: If SDA changes while SCL is high during any of the nine frame bits, `synced` drops to 0 and no word is emitted for that frame.
- R9: If SCL stays high longer than HIGH_CYC cycles inside a frame bit, `synced` drops to 0.
- R10: If SCL stays low longer than LOW_CYC cycles inside a transfer, `synced` drops to 0.
- R11: `capValid` is a single-cycle pulse. `wordCount` rises by exactly one on each pulse and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| capWord | output | 16 | Tagged capture word, valid when `capValid` is 1 |
| capValid | output | 1 | One-cycle strobe marking a new capture word |
| wordCount | output | CNT_W | Number of capture words emitted since reset |
| synced | output | 1 | 1 while the monitor trusts the bus state |

## Verification
The assertions assume that both bus lines are asynchronous to `clk` and that any edge the filter accepts stays stable long enough to be registered into the snapshot. They further assume that SCL and SDA never pass the filter in the same cycle, since the control gives SCL edges priority in that case. The bench drives the lines only on the falling clock edge. It keeps every bus phase at least twenty cycles long, well beyond the filter and synchroniser latency, and it separates each SDA move from the nearest SCL edge by at least that margin. Glitches are injected only with widths well under FILT_LEN ticks, and the only timeout or illegal-change conditions are the deliberate ones in the error scenarios.

// File: rtl/i2c_obs_pkg.sv
package i2c_obs_pkg;

  localparam int CAP_W = 16;

  typedef enum logic [2:0] {
    ST_UNSYNC    = 3'd0,
    ST_HOLD_IDLE = 3'd1,
    ST_IDLE      = 3'd2,
    ST_START     = 3'd3,
    ST_BIT_LOW   = 3'd4,
    ST_BIT_HIGH  = 3'd5,
    ST_POST_LOW  = 3'd6,
    ST_POST_HIGH = 3'd7
  } obsState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic bitClr;
    logic bitOne;
    logic bitInc;
    logic timerClr;
    logic startSet;
    logic startClr;
    logic emitByte;
    logic emitStop;
  } obsCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic sclNow;
    logic sdaNow;
    logic sclRise;
    logic sclFall;
    logic sdaRise;
    logic sdaFall;
    logic sdaChg;
    logic lastBit;
    logic idleDone;
    logic highExp;
    logic lowExp;
  } obsStat_t;

endpackage

// File: rtl/i2c_obs_filter.sv
module i2c_obs_filter #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [CW-1:0] agreeCnt;

  // the output follows the input only after FILT_LEN consecutive differing ticks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cleanOut <= 1'b1;
      agreeCnt <= '0;
    end else if (rawIn == cleanOut) begin
      agreeCnt <= '0;
    end else if (tick) begin
      if (agreeCnt == CW'(FILT_LEN - 1)) begin
        cleanOut <= rawIn;
        agreeCnt <= '0;
      end else begin
        agreeCnt <= agreeCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_obs_datapath.sv
module i2c_obs_datapath
  import i2c_obs_pkg::*;
#(
  parameter int FILT_LEN = 8,
  parameter int FILT_DIV = 16,
  parameter int IDLE_CYC = 5000,
  parameter int HIGH_CYC = 5000,
  parameter int LOW_CYC  = 2500000,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  obsCtrl_t         ctrl,
  output obsStat_t         stat,
  output logic [CAP_W-1:0] capWord,
  output logic             capValid,
  output logic [CNT_W-1:0] wordCount
);
  localparam int MAX_A  = (IDLE_CYC > HIGH_CYC) ? IDLE_CYC : HIGH_CYC;
  localparam int MAX_C  = (MAX_A > LOW_CYC) ? MAX_A : LOW_CYC;
  localparam int TMR_W  = $clog2(MAX_C + 2);
  localparam int DIV_W  = (FILT_DIV > 1) ? $clog2(FILT_DIV) : 1;
  localparam logic [TMR_W-1:0] TMR_MAX  = {TMR_W{1'b1}};
  localparam logic [TMR_W-1:0] IDLE_T   = TMR_W'(IDLE_CYC);
  localparam logic [TMR_W-1:0] HIGH_T   = TMR_W'(HIGH_CYC);
  localparam logic [TMR_W-1:0] LOW_T    = TMR_W'(LOW_CYC);
  localparam int LAST_BIT = 8;

  // bit 1 = scl, bit 0 = sda
  logic [1:0] syncA, syncB, cleanPair, snapNow, snapPrev;
  logic       sampleTick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= 2'b11;
      syncB <= 2'b11;
    end else begin
      syncA <= {sclIn, sdaIn};
      syncB <= syncA;
    end
  end

  generate
    if (FILT_DIV > 1) begin : g_div
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) divCnt <= '0;
        else if (divCnt == DIV_W'(FILT_DIV - 1)) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
      assign sampleTick = (divCnt == '0);
    end else begin : g_nodiv
      assign sampleTick = 1'b1;
    end
  endgenerate

  generate
    for (genvar ln = 0; ln < 2; ln++) begin : g_line
      i2c_obs_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sampleTick),
        .rawIn   (syncB[ln]),
        .cleanOut(cleanPair[ln])
      );
    end
  endgenerate

  // both lines registered together into one snapshot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snapNow  <= 2'b11;
      snapPrev <= 2'b11;
    end else begin
      snapNow  <= cleanPair;
      snapPrev <= snapNow;
    end
  end

  logic [TMR_W-1:0] phaseTmr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phaseTmr <= '0;
    else if (ctrl.timerClr) phaseTmr <= '0;
    else if (phaseTmr != TMR_MAX) phaseTmr <= phaseTmr + 1'b1;
  end

  logic [8:0] shiftReg;
  logic [3:0] bitCnt;
  logic       startFlag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg  <= '0;
      bitCnt    <= '0;
      startFlag <= 1'b0;
    end else begin
      if (ctrl.shiftEn) shiftReg <= {shiftReg[7:0], snapNow[0]};
      if (ctrl.bitClr) bitCnt <= '0;
      else if (ctrl.bitOne) bitCnt <= 4'd1;
      else if (ctrl.bitInc) bitCnt <= bitCnt + 1'b1;
      if (ctrl.startSet) startFlag <= 1'b1;
      else if (ctrl.startClr) startFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capWord   <= '0;
      capValid  <= 1'b0;
      wordCount <= '0;
    end else begin
      capValid <= ctrl.emitByte | ctrl.emitStop;
      if (ctrl.emitByte) begin
        capWord   <= {4'b0000, startFlag, shiftReg[8:1], shiftReg[0], 2'b00};
        wordCount <= wordCount + 1'b1;
      end else if (ctrl.emitStop) begin
        capWord   <= CAP_W'(1);
        wordCount <= wordCount + 1'b1;
      end
    end
  end

  always_comb begin
    stat.sclNow   = snapNow[1];
    stat.sdaNow   = snapNow[0];
    stat.sclRise  = snapNow[1] & ~snapPrev[1];
    stat.sclFall  = ~snapNow[1] & snapPrev[1];
    stat.sdaRise  = snapNow[0] & ~snapPrev[0];
    stat.sdaFall  = ~snapNow[0] & snapPrev[0];
    stat.sdaChg   = snapNow[0] ^ snapPrev[0];
    stat.lastBit  = (bitCnt == 4'(LAST_BIT));
    stat.idleDone = (phaseTmr >= IDLE_T);
    stat.highExp  = (phaseTmr >= HIGH_T);
    stat.lowExp   = (phaseTmr >= LOW_T);
  end
endmodule

// File: rtl/i2c_obs_control.sv
module i2c_obs_control
  import i2c_obs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  obsStat_t stat,
  output obsCtrl_t ctrl,
  output logic     synced
);
  obsState_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_UNSYNC;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctrl      = '0;
    unique case (state)
      ST_UNSYNC: begin
        if (stat.sclNow) nextState = ST_HOLD_IDLE;
      end
      ST_HOLD_IDLE: begin
        if (!stat.sclNow) nextState = ST_UNSYNC;
        else if (!stat.sdaNow || stat.sdaChg) ctrl.timerClr = 1'b1;
        else if (stat.idleDone) nextState = ST_IDLE;
      end
      ST_IDLE: begin
        if (stat.sclFall) nextState = ST_UNSYNC;
        else if (stat.sdaFall) nextState = ST_START;
      end
      ST_START: begin
        if (stat.sclFall) begin
          nextState     = ST_BIT_LOW;
          ctrl.bitClr   = 1'b1;
          ctrl.startSet = 1'b1;
        end else if (stat.highExp) begin
          nextState = ST_UNSYNC;
        end
      end
      ST_BIT_LOW: begin
        if (stat.lowExp) nextState = ST_UNSYNC;
        else if (stat.sclRise) begin
          nextState    = ST_BIT_HIGH;
          ctrl.shiftEn = 1'b1;
        end
      end
      ST_BIT_HIGH: begin
        if (stat.sclFall) begin
          if (stat.lastBit) begin
            nextState     = ST_POST_LOW;
            ctrl.emitByte = 1'b1;
          end else begin
            nextState   = ST_BIT_LOW;
            ctrl.bitInc = 1'b1;
          end
        end else if (stat.sdaChg || stat.highExp) begin
          nextState = ST_UNSYNC;
        end
      end
      ST_POST_LOW: begin
        if (stat.lowExp) nextState = ST_UNSYNC;
        else if (stat.sclRise) begin
          nextState    = ST_POST_HIGH;
          ctrl.shiftEn = 1'b1;
        end
      end
      ST_POST_HIGH: begin
        if (stat.sclFall) begin
          nextState     = ST_BIT_LOW;
          ctrl.bitOne   = 1'b1;
          ctrl.startClr = 1'b1;
        end else if (stat.sdaRise) begin
          nextState     = ST_IDLE;
          ctrl.emitStop = 1'b1;
        end else if (stat.sdaFall) begin
          nextState = ST_START;
        end else if (stat.highExp) begin
          nextState = ST_UNSYNC;
        end
      end
      default: nextState = ST_UNSYNC;
    endcase
    if (nextState != state) ctrl.timerClr = 1'b1;
  end

  assign synced = (state != ST_UNSYNC) && (state != ST_HOLD_IDLE);
endmodule

// File: rtl/i2c_observer.sv
module i2c_observer
  import i2c_obs_pkg::*;
#(
  parameter int FILT_LEN = 8,
  parameter int FILT_DIV = 16,
  parameter int IDLE_CYC = 5000,
  parameter int HIGH_CYC = 5000,
  parameter int LOW_CYC  = 2500000,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic [15:0]      capWord,
  output logic             capValid,
  output logic [CNT_W-1:0] wordCount,
  output logic             synced
);
  obsCtrl_t ctrl;
  obsStat_t stat;

  i2c_obs_datapath #(
    .FILT_LEN(FILT_LEN), .FILT_DIV(FILT_DIV), .IDLE_CYC(IDLE_CYC),
    .HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC), .CNT_W(CNT_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .ctrl     (ctrl),
    .stat     (stat),
    .capWord  (capWord),
    .capValid (capValid),
    .wordCount(wordCount)
  );

  i2c_obs_control u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .stat  (stat),
    .ctrl  (ctrl),
    .synced(synced)
  );
endmodule

// File: rtl/i2c_observer_chk.sv
module i2c_observer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [15:0]      capWord,
  input logic             capValid,
  input logic [CNT_W-1:0] wordCount,
  input logic             synced
);
  // R11: strobe lasts one cycle
  assert_valid_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    capValid |=> !capValid);

  // R11: count steps with each word
  assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    capValid |-> wordCount == $past(wordCount) + 1'b1);

  // R11: count holds between words
  assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !capValid |-> $stable(wordCount));

  // R4: reserved fields of every word are zero
  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capValid |-> (capWord[15:12] == 4'b0000) && !capWord[1]);

  // R7: a word tagged as stop carries nothing else
  assert_stop_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (capValid && capWord[0]) |-> capWord == 16'h0001);

  // R8: no word leaves while the monitor is unsynced
  assert_silent_unsynced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !capValid);
endmodule

bind i2c_observer i2c_observer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .capWord  (capWord),
  .capValid (capValid),
  .wordCount(wordCount),
  .synced   (synced)
);

// File: tb/sim_i2c_observer.sv
module sim_i2c_observer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclDrv = 1'b1;
  logic        sdaDrv = 1'b1;
  logic [15:0] capWord;
  logic        capValid;
  logic [15:0] wordCount;
  logic        synced;

  int nChecks = 0;
  int nFail   = 0;
  int nGot    = 0;
  int dblPulse = 0;
  int expTotal = 0;
  bit done    = 1'b0;
  bit prevValid = 1'b0;
  logic [15:0] got [0:63];

  always #4 clk = ~clk;

  i2c_observer #(
    .FILT_LEN(8), .FILT_DIV(1), .IDLE_CYC(300),
    .HIGH_CYC(150), .LOW_CYC(1000), .CNT_W(16)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sclIn(sclDrv), .sdaIn(sdaDrv),
    .capWord(capWord), .capValid(capValid), .wordCount(wordCount), .synced(synced)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (capValid) begin
        if (nGot < 64) got[nGot] = capWord;
        nGot++;
        if (prevValid) dblPulse++;
      end
      prevValid = capValid;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] byteWord(input logic st, input logic [7:0] d, input logic ack);
    return {4'b0000, st, d, ack, 2'b00};
  endfunction

  task automatic busStart();
    sdaDrv = 1'b0; waitCyc(50);
  endtask

  task automatic busBit(input logic b, input bit glitch);
    sclDrv = 1'b0; waitCyc(10);
    if (glitch) begin sclDrv = 1'b1; waitCyc(3); sclDrv = 1'b0; end
    waitCyc(15);
    sdaDrv = b; waitCyc(25);
    sclDrv = 1'b1; waitCyc(20);
    if (glitch) begin sdaDrv = ~b; waitCyc(3); sdaDrv = b; end
    waitCyc(30);
  endtask

  task automatic busByte(input logic [7:0] d, input logic ack, input bit glitch);
    for (int i = 7; i >= 0; i--) busBit(d[i], glitch);
    busBit(ack, glitch);
  endtask

  task automatic busStop();
    sclDrv = 1'b0; waitCyc(25); sdaDrv = 1'b0; waitCyc(25);
    sclDrv = 1'b1; waitCyc(50); sdaDrv = 1'b1; waitCyc(50);
  endtask

  task automatic busRestart();
    sclDrv = 1'b0; waitCyc(25); sdaDrv = 1'b1; waitCyc(25);
    sclDrv = 1'b1; waitCyc(50); sdaDrv = 1'b0; waitCyc(50);
  endtask

  task automatic busRelease(input string tag);
    sclDrv = 1'b1; waitCyc(30); sdaDrv = 1'b1; waitCyc(400);
    chk(tag, synced, 1);
  endtask

  task automatic testReset();
    waitCyc(5);
    chk("R1 synced in reset", synced, 0);
    chk("R1 count in reset", wordCount, 0);
    chk("R1 valid in reset", capValid, 0);
    rst_n = 1'b1;
    waitCyc(100);
    chk("R2 not synced before idle window", synced, 0);
    waitCyc(300);
    chk("R2 synced after idle window", synced, 1);
  endtask

  task automatic testSingle();
    int base = nGot;
    busStart(); busByte(8'hA5, 1'b0, 1'b0); busStop();
    expTotal += 2;
    chk("R4 single word count", nGot - base, 2);
    chk("R4 single byte word", got[base], byteWord(1'b1, 8'hA5, 1'b0));
    chk("R7 stop word", got[base+1], 16'h0001);
  endtask

  task automatic testMulti();
    int base = nGot;
    busStart(); busByte(8'h3C, 1'b0, 1'b0); busByte(8'hC3, 1'b1, 1'b0); busStop();
    expTotal += 3;
    chk("R5 multi word count", nGot - base, 3);
    chk("R4 first byte", got[base], byteWord(1'b1, 8'h3C, 1'b0));
    chk("R5 continuation byte", got[base+1], byteWord(1'b0, 8'hC3, 1'b1));
    chk("R7 stop after multi", got[base+2], 16'h0001);
  endtask

  task automatic testRestart();
    int base = nGot;
    busStart(); busByte(8'h50, 1'b0, 1'b0); busRestart(); busByte(8'h51, 1'b1, 1'b0); busStop();
    expTotal += 3;
    chk("R6 restart word count", nGot - base, 3);
    chk("R6 byte before restart", got[base], byteWord(1'b1, 8'h50, 1'b0));
    chk("R6 byte after restart", got[base+1], byteWord(1'b1, 8'h51, 1'b1));
    chk("R7 stop after restart", got[base+2], 16'h0001);
  endtask

  task automatic testGlitch();
    int base = nGot;
    busStart(); busByte(8'h96, 1'b0, 1'b1); busStop();
    expTotal += 2;
    chk("R3 glitched word count", nGot - base, 2);
    chk("R3 glitched byte", got[base], byteWord(1'b1, 8'h96, 1'b0));
    chk("R3 synced after glitches", synced, 1);
  endtask

  task automatic testSdaError();
    int base = nGot;
    busStart();
    sclDrv = 1'b0; waitCyc(25); sdaDrv = 1'b1; waitCyc(25);
    sclDrv = 1'b1; waitCyc(25); sdaDrv = 1'b0; waitCyc(30);
    chk("R8 unsynced on sda move", synced, 0);
    chk("R8 no word on error", nGot - base, 0);
    busRelease("R2 resync after sda error");
  endtask

  task automatic testHighTimeout();
    busStart();
    sclDrv = 1'b0; waitCyc(50); sclDrv = 1'b1; waitCyc(100);
    chk("R9 still synced inside high limit", synced, 1);
    waitCyc(200);
    chk("R9 unsynced on long high", synced, 0);
    busRelease("R2 resync after high timeout");
  endtask

  task automatic testLowTimeout();
    busStart();
    sclDrv = 1'b0; waitCyc(800);
    chk("R10 still synced inside low limit", synced, 1);
    waitCyc(400);
    chk("R10 unsynced on long low", synced, 0);
    busRelease("R2 resync after low timeout");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) got[i] = 16'hDEAD;
    testReset();
    testSingle();
    testMulti();
    testRestart();
    testGlitch();
    testSdaError();
    testHighTimeout();
    testLowTimeout();
    chk("R11 word counter total", wordCount, expTotal);
    chk("R11 words seen", nGot, expTotal);
    chk("R11 single-cycle strobes", dblPulse, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule